// File: doc/BRIEF.md
# ADC Scan Sequencer Controller

This block sequences a multi-channel analog-to-digital converter through a group of channels. Software programs it through an 8-bit control register and reads it through a status register, both on a simple synchronous bus. It opens each conversion with a one-cycle start pulse that carries a channel number. The converter closes the conversion with a one-cycle done pulse some cycles later. Only one conversion is outstanding at any time.

Two mode bits set how the scan runs. The first picks the pacing: in free-running mode the next conversion starts as soon as the previous one completes; in triggered mode one conversion runs for each synchronized rising edge on an external trigger pin. The second picks what follows the last channel: continuous mode wraps back to channel 0, and single-pass mode halts. At the end of every pass the block sets a scan-complete flag, which is also driven out as an interrupt line.

Software can restart a scan that halted in single-pass mode in two ways: clear the scan-complete flag while the run bit is set, or switch to continuous mode. Cycling the run bit off and on does not restart it.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control register reads 0x80, the status register reads 0x00, the interrupt output is 0 and no start pulse is issued.
- R2: Control bit 7 always reads 1 and control bit 3 always reads 0, whatever value is written to them.
- R3: A write to the channel field (control bits 2:0) takes effect only while the stored run bit (control bit 4) is 0. Otherwise the field keeps its value.
- R4: The run bit reads back as written. Setting it starts a scan at channel 0. Clearing it stops the scan, and no further start pulses are issued.
- R5: With control bit 5 = 0 (free-running mode), the block converts channels 0 through N in ascending order, where N is the channel field. Each start pulse lasts one cycle and follows the done pulse of the previous conversion.
- R6: With control bit 5 = 1 (triggered mode), no conversion starts without a trigger edge. Each rising edge of the trigger input, passed through a two-flop synchronizer, starts exactly one conversion.
- R7: Trigger edges that arrive while a conversion is outstanding are ignored.
- R8: With control bit 6 = 0 (continuous mode), the conversion after channel N is channel 0.
- R9: With control bit 6 = 1 (single-pass mode), the scan halts after the done pulse of channel N.
- R10: The scan-complete flag (status bit 0, mirrored on the interrupt output) is set by the done pulse of channel N. A status write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. A set in the same cycle as a clear wins.
- R11: In single-pass mode, a halted scan restarts at channel 0 when the flag is cleared while the run bit is 1.
- R12: A halted single-pass scan does not restart when the run bit is cleared and then set again.
- R13: Clearing control bit 6 while the scan is halted restarts scanning in continuous mode at channel 0, without any write to the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = control, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the register selected in the previous cycle |
| trig_in | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Channel number for the conversion being started |
| conv_done | input | 1 | One-cycle conversion done pulse from the converter |
| scan_irq | output | 1 | Scan-complete flag |

## Verification
A wrong channel counter shows up as an out-of-order or out-of-range channel on the first start pulse after the fault, so the bench logs every start and compares the whole log with the ascending, wrapping order. A wrong halt state shows up either as extra start pulses after a single pass or as a scan that never restarts. These are checked over windows of tens of cycles, after run-bit toggles, flag clears and mode changes. Faults in trigger handling show up as a start with no edge, or as a second start produced by edges that arrived during a busy conversion.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CTRL_RUN    = 4;
  localparam int CTRL_TRIG   = 5;
  localparam int CTRL_SINGLE = 6;
  localparam int CTRL_ONE    = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_BUSY  = 2'd2,
    ST_HALT  = 2'd3
  } scan_state_t;
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          flag_set,
  output logic [CW-1:0] last_ch,
  output logic          run,
  output logic          trig_mode,
  output logic          single_pass,
  output logic          flag
);
  logic [DW-1:0] ctrl_view;
  logic          wr_ctrl, wr_stat;
  logic          unused_wbits;

  assign wr_ctrl = bus_we && (bus_addr == 1'b0);
  assign wr_stat = bus_we && (bus_addr == 1'b1);
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[CW-1:0]      = last_ch;
    ctrl_view[CTRL_RUN]    = run;
    ctrl_view[CTRL_TRIG]   = trig_mode;
    ctrl_view[CTRL_SINGLE] = single_pass;
    ctrl_view[CTRL_ONE]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_ch     <= '0;
      run         <= 1'b0;
      trig_mode   <= 1'b0;
      single_pass <= 1'b0;
      flag        <= 1'b0;
      bus_rdata   <= DW'(8'h80);
    end else begin
      if (wr_ctrl) begin
        if (!run) last_ch <= bus_wdata[CW-1:0];
        run         <= bus_wdata[CTRL_RUN];
        trig_mode   <= bus_wdata[CTRL_TRIG];
        single_pass <= bus_wdata[CTRL_SINGLE];
      end
      if (flag_set)
        flag <= 1'b1;
      else if (wr_stat && !bus_wdata[0])
        flag <= 1'b0;
      bus_rdata <= bus_addr ? DW'(flag) : ctrl_view;
    end
  end

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_addr) |-> (bus_rdata[CTRL_ONE] && !bus_rdata[3])); // R2
  AST_CHAN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && run) |=> $stable(last_ch)); // R3
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    flag_set |=> flag); // R10
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !bus_wdata[0] && !flag_set) |=> !flag); // R10
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic trig_edge
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign trig_edge = sync_q[STAGES-1] && !prev_q;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trig_edge |=> !trig_edge); // R6
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          trig_mode,
  input  logic          single_pass,
  input  logic          flag,
  input  logic [CW-1:0] last_ch,
  input  logic          trig_edge,
  input  logic          conv_done,
  output logic          conv_start,
  output logic [CW-1:0] conv_chan,
  output logic          flag_set
);
  scan_state_t   state;
  logic [CW-1:0] cur_ch;
  logic          go;
  logic          done_in_busy;

  assign go           = !trig_mode || trig_edge;
  assign done_in_busy = (state == ST_BUSY) && conv_done;
  assign flag_set     = done_in_busy && (cur_ch == last_ch);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_ch     <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (run) begin
            cur_ch <= '0;
            state  <= ST_READY;
          end
        end
        ST_READY: begin
          if (!run) begin
            state <= ST_IDLE;
          end else if (go) begin
            conv_start <= 1'b1;
            conv_chan  <= cur_ch;
            state      <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (!run) begin
            state <= ST_IDLE;
          end else if (conv_done) begin
            if (cur_ch == last_ch) begin
              cur_ch <= '0;
              state  <= single_pass ? ST_HALT : ST_READY;
            end else begin
              cur_ch <= cur_ch + 1'b1;
              state  <= ST_READY;
            end
          end
        end
        default: begin
          if (!single_pass) begin
            cur_ch <= '0;
            state  <= run ? ST_READY : ST_IDLE;
          end else if (run && !flag) begin
            cur_ch <= '0;
            state  <= ST_READY;
          end
        end
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R5
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (conv_chan <= last_ch)); // R5
  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (rst)
    ($past(trig_mode) && conv_start) |-> $past(trig_edge)); // R6
  AST_HALT_NO_START: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |=> !conv_start); // R12
  AST_STOP_NO_START: assert property (@(posedge clk) disable iff (rst)
    !run |=> !conv_start); // R4
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int DW          = 8,
  parameter int CW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          trig_in,
  output logic          conv_start,
  output logic [CW-1:0] conv_chan,
  input  logic          conv_done,
  output logic          scan_irq
);
  logic [CW-1:0] last_ch;
  logic          run, trig_mode, single_pass, flag, flag_set, trig_edge;

  adc_scan_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_set(flag_set),
    .last_ch(last_ch), .run(run), .trig_mode(trig_mode),
    .single_pass(single_pass), .flag(flag)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_in(trig_in), .trig_edge(trig_edge)
  );

  adc_scan_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .run(run), .trig_mode(trig_mode),
    .single_pass(single_pass), .flag(flag), .last_ch(last_ch),
    .trig_edge(trig_edge), .conv_done(conv_done), .conv_start(conv_start),
    .conv_chan(conv_chan), .flag_set(flag_set)
  );

  assign scan_irq = flag;

  AST_IRQ_ON_PASS: assert property (@(posedge clk) disable iff (rst)
    (conv_done && flag_set) |=> scan_irq); // R10
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       trig_in = 1'b0;
  logic       conv_start;
  logic [2:0] conv_chan;
  logic       conv_done = 1'b0;
  logic       scan_irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int nstart = 0;
  int lat = 3;
  int busy_cnt = 0;
  logic [2:0] chlog [0:1023];

  always #10 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .scan_irq(scan_irq)
  );

  // converter responder: sampled and driven on the falling edge
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt == 0) conv_done = 1'b1;
    end
    if (conv_start) begin
      if (nstart < 1024) chlog[nstart] = conv_chan;
      nstart = nstart + 1;
      busy_cnt = lat;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [2:0] exp_ch(input int idx, input int last);
    return 3'(idx % (last + 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    wait_cyc(4);
    trig_in = 1'b0;
    wait_cyc(4);
  endtask

  function automatic bit log_ok(input int from, input int cnt, input int last);
    for (int i = 0; i < cnt; i++)
      if (chlog[from + i] !== exp_ch(i, last)) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    logic [7:0] d;
    int n0, last;
    bit ok;
    void'($urandom(32'd1234));
    wait_cyc(3);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(1'b0, d); chk(d == 8'h80, "R1 ctrl", d, 8'h80);
    rd(1'b1, d); chk(d == 8'h00, "R1 status", d, 0);
    chk(scan_irq == 1'b0 && nstart == 0, "R1 idle", nstart, 0);

    // R2 fixed bits
    wr(1'b0, 8'h08); rd(1'b0, d); chk(d == 8'h80, "R2 bit3", d, 8'h80);
    wr(1'b0, 8'h6F); rd(1'b0, d); chk(d == 8'hE7, "R2 mixed", d, 8'hE7);
    wr(1'b0, 8'h00);

    // R5 R8 random free-running continuous scans
    for (int r = 0; r < 8; r++) begin
      last = int'($urandom % 8);
      lat = 1 + int'($urandom % 6);
      wr(1'b0, 8'(last));
      wait_cyc(10);
      nstart = 0;
      wr(1'b0, 8'h10 | 8'(last));
      wait_cyc(40 + int'($urandom % 60));
      wr(1'b0, 8'(last));
      wait_cyc(12);
      ok = (nstart > last + 1) && log_ok(0, nstart, last);
      chk(ok, "R5 R8 order and wrap", nstart, last + 2);
    end

    // R3 channel field locked while running; R4 readback
    lat = 2;
    wr(1'b0, 8'h03); wr(1'b0, 8'h13);
    wr(1'b0, 8'h11);
    rd(1'b0, d); chk(d == 8'h93, "R3 locked field / R4 run readback", d, 8'h93);
    wr(1'b0, 8'h01);
    wait_cyc(12);
    n0 = nstart;
    wait_cyc(40);
    chk(nstart == n0, "R4 stop", nstart, n0);
    wr(1'b0, 8'h01); rd(1'b0, d); chk(d == 8'h81, "R3 write while stopped", d, 8'h81);

    // R6 R7 triggered mode
    wr(1'b0, 8'h03);
    wait_cyc(10);
    nstart = 0; lat = 3;
    wr(1'b0, 8'h33);
    wait_cyc(30);
    chk(nstart == 0, "R6 no start without edge", nstart, 0);
    pulse_trig(); wait_cyc(4);
    chk(nstart == 1 && chlog[0] == 3'd0, "R6 one start per edge", nstart, 1);
    lat = 40;
    pulse_trig(); wait_cyc(2);
    chk(nstart == 2 && chlog[1] == 3'd1, "R6 second edge", nstart, 2);
    pulse_trig(); pulse_trig();
    wait_cyc(40);
    chk(nstart == 2, "R7 edges while busy ignored", nstart, 2);
    lat = 3;
    pulse_trig(); wait_cyc(4);
    chk(nstart == 3 && chlog[2] == 3'd2, "R7 edge after done", nstart, 3);
    wr(1'b0, 8'h03);
    wait_cyc(50);

    // R9 single pass
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h02);
    nstart = 0; lat = 3;
    wr(1'b0, 8'h52);
    wait_cyc(60);
    chk(nstart == 3 && log_ok(0, 3, 2), "R9 single pass", nstart, 3);
    rd(1'b1, d); chk(d == 8'h01 && scan_irq, "R10 flag set on pass", d, 1);

    // R12 run toggle does not restart
    wr(1'b0, 8'h42); wait_cyc(5); wr(1'b0, 8'h52);
    wait_cyc(60);
    chk(nstart == 3, "R12 run toggle no restart", nstart, 3);

    // R10 hold on write of 1
    wr(1'b1, 8'h01); rd(1'b1, d); chk(d == 8'h01, "R10 write 1 holds", d, 1);

    // R11 restart by flag clear, R10 clear
    wr(1'b1, 8'h00); rd(1'b1, d); chk(d == 8'h00, "R10 write 0 clears", d, 0);
    wait_cyc(60);
    chk(nstart == 6 && log_ok(3, 3, 2), "R11 restart on flag clear", nstart, 6);
    chk(scan_irq == 1'b1, "R10 flag set again", scan_irq, 1);

    // R13 leave single-pass while halted
    wr(1'b0, 8'h12);
    wait_cyc(80);
    ok = (nstart > 10) && log_ok(6, nstart - 6, 2);
    chk(ok, "R13 continuous restart", nstart, 11);
    wr(1'b0, 8'h02);
    wait_cyc(20);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule